// File: doc/BRIEF.md
# Q-Subcode Serial Readout

This block sits between a disc subcode decoder and a host microcontroller. Each time the decoder presents an 80-bit Q-channel word together with the result of its CRC check, the block decides whether the word is worth offering to the host. If it is, the block stores the word in a holding register and raises a ready flag. The host then clocks the word out bit by bit on its own read clock, least significant bit first.

Once the host has started clocking, the stored word is frozen so that it cannot change partway through a read. When the read ends, either after all 80 bits or because the host clock stopped, the ready flag is raised for a short window. During that window a fresh word may be accepted. The flag also drops by itself if the host never reads, about 11.2 ms after it rose.

The host read clock is asynchronous to the system clock and is sampled through a synchroniser. The serial data pin is released to high impedance whenever the host's output-enable level is high.

Top module: `subq_reader`

## Requirements
- R1: Serial data goes out least significant bit first. Bit 0 of the held word is presented before the first host clock edge, and each recognised rising edge of the host read clock advances the output by one bit. A rising edge of the host clock is seen by two synchroniser flops and takes effect on the third system clock edge after it is first sampled. Host clock edges while the ready flag is low and no read is in progress are ignored.
- R2: A word strobe is accepted only when the CRC-ok input is 1 and the address field, bits [3:0] of the word, equals 1. An accepted word is stored, and the ready flag is high from the next clock. Any other strobe leaves the stored word and the flag unchanged.
- R3: When the address-free input is 1, the address field is not examined. A strobe with CRC-ok equal to 1 is then accepted whatever bits [3:0] hold, and a strobe with CRC-ok equal to 0 is still rejected.
- R4: From the first recognised host edge until the read ends, the ready flag is low and accepted-looking strobes are ignored, so the stored word stays as it was.
- R5: The word is ten bytes, with byte k at bits [8k+7:8k], so the bytes leave in index order. Byte 0 is control/address (address in its low nibble). Then come track number, index, minute, second, frame, a zero byte, absolute minute, absolute second and absolute frame.
- R6: When a read ends, the ready flag is high for exactly PULSE_CYC clocks and the output returns to bit 0 of the stored word. A qualifying strobe during that window is stored, and the flag stays high as a new ready period. Without such a strobe the flag falls.
- R7: If no host edge arrives, the ready flag stays high for exactly TIMEOUT_CYC = floor(SYS_CLK_KHZ*112/10) clocks, which is 11.2 ms. A qualifying strobe while ready replaces the stored word and restarts this count.
- R8: While the output-enable input is 1 the serial data pin is high impedance. While it is 0 the pin drives the current bit.
- R9: If, during a read, no host edge is recognised for GAP_CYC clocks, the read ends early. The bit position returns to 0 and the R6 window follows.
- R10: After a synchronous reset the ready flag is 0, the stored word is all zeros and the output presents its bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| q_word_i | input | 80 | Parallel Q word, byte k at bits [8k+7:8k] |
| q_stb_i | input | 1 | One-clock strobe marking a new Q word |
| q_crc_ok_i | input | 1 | CRC result for the strobed word, 1 = pass |
| addr_free_i | input | 1 | 1 = ignore the address field when qualifying |
| rd_clk_i | input | 1 | Host read clock, asynchronous |
| rd_en_n_i | input | 1 | Host output enable, 0 = drive data pin |
| q_ready_o | output | 1 | Ready flag to the host |
| q_sdo_o | output | 1 | Serial data, high impedance when disabled |

## Verification
A wrong bit position or a stale shift register shows directly on the data pin within one host clock period, because the bench compares that pin with a behavioural model on every system clock. A wrong internal state shows on the ready flag in the clock after the mistaken transition. For example, a word accepted while frozen would show as a ready flag that stays high, and a timer that counts wrongly would move the falling edge of the flag by the same number of clocks. Early release of the freeze, a missed timeout, or a read-end window of the wrong length are therefore visible at the ports within tens of clocks.

// File: rtl/subq_pkg.sv
package subq_pkg;

  // Read-path phases
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,  // nothing offered to the host
    ST_ARMED   = 2'd1,  // word held, ready flag high, waiting for host clock
    ST_SHIFT   = 2'd2,  // host is clocking, word frozen
    ST_HOLDOFF = 2'd3   // read over, short ready window for an update
  } rd_state_t;

  localparam int unsigned FIELD_W  = 8;   // bits per field
  localparam int unsigned FIELD_N  = 10;  // fields per Q word
  localparam int unsigned ADR_W    = 4;   // address field width, low nibble of byte 0
  localparam logic [ADR_W-1:0] ADR_MATCH = 4'd1;

endpackage

// File: rtl/subq_edge_sync.sv
module subq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  // chain[0..STAGES-1] synchronise, chain[STAGES] is the edge-detect history
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/subq_qualify.sv
module subq_qualify
  import subq_pkg::*;
(
  input  logic             stb_i,
  input  logic             crc_ok_i,
  input  logic             addr_free_i,
  input  logic [ADR_W-1:0] adr_i,
  output logic             accept_o
);
  logic adr_hit;

  always_comb begin
    adr_hit  = addr_free_i || (adr_i == ADR_MATCH);
    accept_o = stb_i && crc_ok_i && adr_hit;
  end
endmodule

// File: rtl/subq_shifter.sv
module subq_shifter #(
  parameter int unsigned WORD_W = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              restore_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] hold_q;   // copy kept for repeat reads
  logic [WORD_W-1:0] shreg_q;  // working copy, LSB on the pin

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      shreg_q <= '0;
    end else if (load_i) begin
      hold_q  <= word_i;
      shreg_q <= word_i;
    end else if (restore_i) begin
      shreg_q <= hold_q;
    end else if (shift_i) begin
      shreg_q <= {1'b0, shreg_q[WORD_W-1:1]};
    end
  end

  assign bit_o = shreg_q[0];
endmodule

// File: rtl/subq_ctrl.sv
module subq_ctrl
  import subq_pkg::*;
#(
  parameter int unsigned WORD_W      = 80,
  parameter int unsigned TIMEOUT_CYC = 189660,
  parameter int unsigned GAP_CYC     = 4096,
  parameter int unsigned PULSE_CYC   = 64
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      accept_i,
  input  logic      rise_i,
  output logic      load_o,
  output logic      shift_o,
  output logic      restore_o,
  output logic      ready_o,
  output rd_state_t state_o
);
  localparam int unsigned MAX_AB  = (TIMEOUT_CYC > GAP_CYC) ? TIMEOUT_CYC : GAP_CYC;
  localparam int unsigned TMR_MAX = (MAX_AB > PULSE_CYC) ? MAX_AB : PULSE_CYC;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned BIT_W   = $clog2(WORD_W + 1);
  localparam logic [TMR_W-1:0] TO_LAST    = TMR_W'(TIMEOUT_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_LAST   = TMR_W'(GAP_CYC - 1);
  localparam logic [TMR_W-1:0] PULSE_LAST = TMR_W'(PULSE_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(WORD_W - 1);

  rd_state_t        st_q, st_nx;
  logic [TMR_W-1:0] tmr_q, tmr_nx;
  logic [BIT_W-1:0] bits_q, bits_nx;

  always_comb begin
    st_nx     = st_q;
    tmr_nx    = tmr_q;
    bits_nx   = bits_q;
    load_o    = 1'b0;
    shift_o   = 1'b0;
    restore_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept_i) begin
          load_o = 1'b1;
          tmr_nx = '0;
          st_nx  = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (rise_i) begin
          shift_o = 1'b1;
          bits_nx = BIT_W'(1);
          tmr_nx  = '0;
          st_nx   = ST_SHIFT;
        end else if (accept_i) begin
          load_o = 1'b1;
          tmr_nx = '0;
        end else if (tmr_q == TO_LAST) begin
          tmr_nx = '0;
          st_nx  = ST_IDLE;
        end else begin
          tmr_nx = tmr_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (rise_i) begin
          tmr_nx = '0;
          if (bits_q == LAST_BIT) begin
            restore_o = 1'b1;
            bits_nx   = '0;
            st_nx     = ST_HOLDOFF;
          end else begin
            shift_o = 1'b1;
            bits_nx = bits_q + 1'b1;
          end
        end else if (tmr_q == GAP_LAST) begin
          restore_o = 1'b1;
          bits_nx   = '0;
          tmr_nx    = '0;
          st_nx     = ST_HOLDOFF;
        end else begin
          tmr_nx = tmr_q + 1'b1;
        end
      end
      ST_HOLDOFF: begin
        if (accept_i) begin
          load_o = 1'b1;
          tmr_nx = '0;
          st_nx  = ST_ARMED;
        end else if (tmr_q == PULSE_LAST) begin
          tmr_nx = '0;
          st_nx  = ST_IDLE;
        end else begin
          tmr_nx = tmr_q + 1'b1;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      tmr_q   <= '0;
      bits_q  <= '0;
      ready_o <= 1'b0;
    end else begin
      st_q    <= st_nx;
      tmr_q   <= tmr_nx;
      bits_q  <= bits_nx;
      ready_o <= (st_nx == ST_ARMED) || (st_nx == ST_HOLDOFF);
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/subq_reader.sv
module subq_reader
  import subq_pkg::*;
#(
  parameter int unsigned SYS_CLK_KHZ = 16934,
  parameter int unsigned GAP_CYC     = 4096,
  parameter int unsigned PULSE_CYC   = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [FIELD_W*FIELD_N-1:0] q_word_i,
  input  logic                       q_stb_i,
  input  logic                       q_crc_ok_i,
  input  logic                       addr_free_i,
  input  logic                       rd_clk_i,
  input  logic                       rd_en_n_i,
  output logic                       q_ready_o,
  output logic                       q_sdo_o
);
  localparam int unsigned WORD_W      = FIELD_W * FIELD_N;
  localparam int unsigned TIMEOUT_CYC = (SYS_CLK_KHZ * 112) / 10;  // 11.2 ms

  logic      rd_rise;
  logic      accept;
  logic      do_load, do_shift, do_restore;
  logic      sdo_bit;
  rd_state_t cur_st;

  subq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (rd_clk_i),
    .rise_o  (rd_rise)
  );

  subq_qualify u_qual (
    .stb_i       (q_stb_i),
    .crc_ok_i    (q_crc_ok_i),
    .addr_free_i (addr_free_i),
    .adr_i       (q_word_i[ADR_W-1:0]),
    .accept_o    (accept)
  );

  subq_ctrl #(
    .WORD_W      (WORD_W),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .GAP_CYC     (GAP_CYC),
    .PULSE_CYC   (PULSE_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .accept_i  (accept),
    .rise_i    (rd_rise),
    .load_o    (do_load),
    .shift_o   (do_shift),
    .restore_o (do_restore),
    .ready_o   (q_ready_o),
    .state_o   (cur_st)
  );

  subq_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load_i    (do_load),
    .shift_i   (do_shift),
    .restore_i (do_restore),
    .word_i    (q_word_i),
    .bit_o     (sdo_bit)
  );

  assign q_sdo_o = rd_en_n_i ? 1'bz : sdo_bit;
endmodule

// File: rtl/subq_reader_chk.sv
module subq_reader_chk
  import subq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 22,
  parameter int unsigned PULSE_CYC   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [ADR_W-1:0] adr,
  input logic             q_stb_i,
  input logic             q_crc_ok_i,
  input logic             addr_free_i,
  input logic             q_ready_o,
  input logic             rd_rise,
  input logic             sdo_bit,
  input rd_state_t        cur_st
);
  logic port_qual;
  int   armed_run;
  int   hold_run;

  assign port_qual = q_stb_i && q_crc_ok_i && (addr_free_i || adr == ADR_MATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_run <= 0;
      hold_run  <= 0;
    end else begin
      armed_run <= (cur_st == ST_ARMED && !port_qual && !rd_rise) ? armed_run + 1 : 0;
      hold_run  <= (cur_st == ST_HOLDOFF && !port_qual) ? hold_run + 1 : 0;
    end
  end

  AST_RISE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (rst)
    ($rose(q_ready_o) && $past(cur_st) != ST_SHIFT) |-> $past(port_qual)); // R2

  AST_BAD_CRC_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (cur_st == ST_IDLE && q_stb_i && !q_crc_ok_i) |=> !q_ready_o); // R2

  AST_LOW_WHILE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (cur_st == ST_SHIFT) |-> !q_ready_o); // R4

  AST_FROZEN_BIT: assert property (@(posedge clk) disable iff (rst)
    (cur_st == ST_SHIFT && !rd_rise) |=> ($stable(sdo_bit) || cur_st == ST_HOLDOFF)); // R4

  AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (rst)
    armed_run <= int'(TIMEOUT_CYC)); // R7

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    hold_run <= int'(PULSE_CYC)); // R6
endmodule

bind subq_reader subq_reader_chk #(
  .TIMEOUT_CYC (TIMEOUT_CYC),
  .PULSE_CYC   (PULSE_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .adr         (q_word_i[ADR_W-1:0]),
  .q_stb_i     (q_stb_i),
  .q_crc_ok_i  (q_crc_ok_i),
  .addr_free_i (addr_free_i),
  .q_ready_o   (q_ready_o),
  .rd_rise     (rd_rise),
  .sdo_bit     (sdo_bit),
  .cur_st      (cur_st)
);

// File: tb/subq_reader_tb_top.sv
module subq_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ   = 2;
  localparam int GAP   = 16;
  localparam int PULSE = 4;
  localparam int TMO   = (KHZ * 112) / 10;  // R7 formula
  localparam int W     = 80;
  localparam int HALF  = 6;                  // host clock half period in system clocks

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] qw = '0;
  logic         stb = 1'b0, crc = 1'b0, afree = 1'b0, rd_clk = 1'b0, en_n = 1'b0;
  logic         ready;
  wire          sdo_w;
  pullup pu_i (sdo_w);  // released pin reads 1 on the bench net

  int  n_cmp = 0, n_bad = 0;
  bit  cmp_on = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subq_reader #(.SYS_CLK_KHZ(KHZ), .GAP_CYC(GAP), .PULSE_CYC(PULSE)) dut_i (
    .clk(clk), .rst(rst), .q_word_i(qw), .q_stb_i(stb), .q_crc_ok_i(crc),
    .addr_free_i(afree), .rd_clk_i(rd_clk), .rd_en_n_i(en_n),
    .q_ready_o(ready), .q_sdo_o(sdo_w)
  );

  // ---------------- behavioural reference model ----------------
  int           m_mode = 0, m_cnt = 0, m_pos = 0;
  logic [W-1:0] m_word = '0;
  bit           m_ready = 1'b0;
  bit           hist[$] = '{1'b0, 1'b0, 1'b0};

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_pos = 0; m_word = '0; m_ready = 1'b0;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      bit seen, qual;
      seen = hist[1] && !hist[0];  // two-sample old high, three-sample old low
      qual = stb && crc && (afree || qw[3:0] == 4'd1);
      case (m_mode)
        0: if (qual) begin m_word = qw; m_pos = 0; m_cnt = 0; m_mode = 1; end
        1: if (seen) begin m_pos = 1; m_cnt = 0; m_mode = 2; end
           else if (qual) begin m_word = qw; m_pos = 0; m_cnt = 0; end
           else if (m_cnt == TMO - 1) begin m_cnt = 0; m_mode = 0; end
           else m_cnt++;
        2: if (seen) begin
             m_cnt = 0; m_pos++;
             if (m_pos == W) begin m_pos = 0; m_mode = 3; end
           end else if (m_cnt == GAP - 1) begin m_pos = 0; m_cnt = 0; m_mode = 3; end
           else m_cnt++;
        default: if (qual) begin m_word = qw; m_pos = 0; m_cnt = 0; m_mode = 1; end
           else if (m_cnt == PULSE - 1) begin m_cnt = 0; m_mode = 0; end
           else m_cnt++;
      endcase
      m_ready = (m_mode == 1) || (m_mode == 3);
      void'(hist.pop_front());
      hist.push_back(rd_clk);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      logic exp_bit;
      exp_bit = en_n ? 1'b1 : m_word[m_pos];
      n_cmp++;
      if (ready !== m_ready) begin
        n_bad++;
        $display("FAIL R2 ready per-clock: actual %b expected %b at %0t", ready, m_ready, $time);
      end
      n_cmp++;
      if (sdo_w !== exp_bit) begin
        n_bad++;
        $display("FAIL R1 sdo per-clock: actual %b expected %b at %0t", sdo_w, exp_bit, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mkq(input logic [7:0] ca, tr, ix, mi, se, fr, am, as_, af);
    return {af, as_, am, 8'h00, fr, se, mi, ix, tr, ca};
  endfunction

  task automatic send(input logic [W-1:0] w, input logic ok);
    qw = w; crc = ok; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0; crc = 1'b0;
  endtask

  // Clock nbits host edges; sample each bit before its edge. Counts ready-high
  // samples during the last bit's period; injects a strobe during bit inj_at.
  task automatic host_bits(input int nbits, output logic [W-1:0] got, output int hi_last,
                           input int inj_at, input logic [W-1:0] inj);
    got = '0; hi_last = 0;
    for (int i = 0; i < nbits; i++) begin
      got[i] = sdo_w;
      rd_clk = 1'b1;
      for (int c = 0; c < HALF; c++) begin
        @(negedge clk);
        if (i == nbits - 1 && ready) hi_last++;
      end
      if (i == 0) chk(ready == 1'b0, "R4 ready low once clocking began", W'(ready), '0);
      rd_clk = 1'b0;
      for (int c = 0; c < HALF; c++) begin
        if (i == inj_at && c == 0) begin qw = inj; crc = 1'b1; stb = 1'b1; end
        @(negedge clk);
        if (i == inj_at && c == 0) begin stb = 1'b0; crc = 1'b0; end
        if (i == nbits - 1 && ready) hi_last++;
      end
    end
  endtask

  task automatic count_ready(output int n);
    n = 0;
    while (ready && n < 1000) begin n++; @(negedge clk); end
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    logic [W-1:0] w1, w2, w3, wa, wb, got;
    int hi, n;
    w1 = mkq(8'h41, 8'h05, 8'h01, 8'h03, 8'h27, 8'h14, 8'h12, 8'h48, 8'h70);
    w2 = mkq(8'h01, 8'h09, 8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66);
    w3 = mkq(8'h42, 8'h99, 8'h00, 8'h59, 8'h58, 8'h74, 8'h72, 8'h01, 8'h02);
    wa = mkq(8'h41, 8'h10, 8'h01, 8'h00, 8'h02, 8'h30, 8'h00, 8'h04, 8'h05);
    wb = mkq(8'hC1, 8'h7E, 8'h03, 8'h08, 8'h15, 8'h2A, 8'h35, 8'h3B, 8'h4A);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp_on = 1'b1;
    chk(ready == 1'b0, "R10 ready after reset", W'(ready), '0);
    chk(sdo_w == 1'b0, "R10 output bit after reset", W'(sdo_w), '0);

    // accept and full read, with an update attempt in the middle
    send(w1, 1'b1);
    chk(ready == 1'b1, "R2 ready after qualifying word", W'(ready), W'(1));
    host_bits(W, got, hi, 40, w2);
    chk(got == w1, "R1 serial word LSB first", got, w1);
    chk(got == w1, "R4 mid-read strobe ignored", got, w1);
    chk(got[7:0] == 8'h41 && got[31:24] == 8'h03 && got[79:72] == 8'h70,
        "R5 field order", got, w1);
    chk(hi == PULSE, "R6 read-end window length", W'(hi), W'(PULSE));
    chk(sdo_w == w1[0], "R6 output back to bit 0", W'(sdo_w), W'(w1[0]));
    chk(ready == 1'b0, "R6 ready low after window", W'(ready), '0);

    // rejections
    send(w1 ^ {W{1'b0}} | W'(80'h100), 1'b0);
    chk(ready == 1'b0, "R2 bad CRC rejected", W'(ready), '0);
    send(w3, 1'b1);
    chk(ready == 1'b0, "R2 address 2 rejected", W'(ready), '0);
    chk(sdo_w == 1'b1, "R2 stored word kept", W'(sdo_w), W'(1));

    // host edge while idle
    rd_clk = 1'b1; repeat (HALF) @(negedge clk);
    rd_clk = 1'b0; repeat (HALF) @(negedge clk);
    chk(sdo_w == 1'b1 && ready == 1'b0, "R1 idle host edge ignored", W'(sdo_w), W'(1));

    // address-free mode
    afree = 1'b1;
    send(w3, 1'b1);
    chk(ready == 1'b1, "R3 address ignored", W'(ready), W'(1));
    host_bits(W, got, hi, -1, '0);
    chk(got == w3, "R3 address-free word read", got, w3);
    send(w2, 1'b0);
    chk(ready == 1'b0, "R3 CRC still required", W'(ready), '0);
    afree = 1'b0;

    // timeout
    send(wa, 1'b1);
    count_ready(n);
    chk(n == TMO, "R7 timeout length", W'(n), W'(TMO));
    send(wa, 1'b1);
    repeat (9) @(negedge clk);
    send(wb, 1'b1);
    count_ready(n);
    chk(n == TMO, "R7 timeout restarted by new word", W'(n), W'(TMO));
    send(wa, 1'b1);
    repeat (9) @(negedge clk);
    send(wb, 1'b1);
    host_bits(W, got, hi, -1, '0);
    chk(got == wb, "R7 new word replaced held word", got, wb);

    // high impedance
    afree = 1'b1;
    send(w3, 1'b1);
    afree = 1'b0;
    en_n = 1'b1; @(negedge clk);
    chk(sdo_w == 1'b1, "R8 pin released", W'(sdo_w), W'(1));
    en_n = 1'b0; @(negedge clk);
    chk(sdo_w == 1'b0, "R8 pin driven", W'(sdo_w), '0);
    host_bits(W, got, hi, -1, '0);
    chk(got == w3, "R8 read after release", got, w3);

    // host clock stops mid-read
    send(wa, 1'b1);
    host_bits(5, got, hi, -1, '0);
    chk(sdo_w == wa[5], "R9 position held before gap", W'(sdo_w), W'(wa[5]));
    n = 0;
    for (int c = 0; c < 40; c++) begin @(negedge clk); if (ready) n++; end
    chk(n == PULSE, "R9 gap ends read with window", W'(n), W'(PULSE));
    chk(sdo_w == wa[0], "R9 position reset", W'(sdo_w), W'(wa[0]));

    // word accepted during the read-end window
    send(wa, 1'b1);
    host_bits(3, got, hi, -1, '0);
    n = 0;
    while (!ready && n < 60) begin @(negedge clk); n++; end
    send(wb, 1'b1);
    repeat (PULSE + 4) @(negedge clk);
    chk(ready == 1'b1, "R6 window accepts new word", W'(ready), W'(1));
    host_bits(W, got, hi, -1, '0);
    chk(got == wb, "R6 new word read", got, wb);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule